// File: doc/BRIEF.md
# Configurable NaN Classifier and Quieter

This block inspects one binary32 or binary64 operand and reports whether it is an ordinary value, a quiet NaN or a signaling NaN. The test looks at the top bit of the fraction field. A run-time polarity input says whether that bit being set marks a signaling NaN (legacy convention) or a quiet NaN (2008 convention). A separate mode input suppresses signaling NaNs altogether. In that mode every NaN reads as quiet.

Alongside the class, the block returns two patterns for the selected format. The first is the quieted form of the operand. The second is the default NaN selected by a three-bit convention code. Floating-point datapaths use it as a one-cycle helper at the point where a NaN result must be chosen or generated. Inputs are captured under a valid strobe and all results appear, registered, on the following cycle.

Top module: `nan_shaper`

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge that samples `in_valid` high, and low otherwise. Reset drives `out_valid` and all result outputs to zero.
- R2: With `in_msb_sig`=0, a NaN is an operand whose exponent is all ones and whose fraction is nonzero. Such an operand is quiet when the fraction top bit (bit 22 single, bit 51 double) is 1 and signaling when it is 0. The sign bit has no effect.
- R3: With `in_msb_sig`=1 the roles swap: a NaN whose fraction top bit is 1 is signaling, and a NaN whose top bit is 0 is quiet.
- R4: An operand whose exponent is all ones and whose fraction is zero (infinity), and any operand with a different exponent, raises neither `out_is_qnan` nor `out_is_snan`.
- R5: With `in_no_snan`=1, `out_is_snan` is 0 and every NaN raises `out_is_qnan`.
- R6: With `in_msb_sig`=0, the quieted form of a signaling NaN is the operand with the fraction top bit set. All other bits are kept.
- R7: With `in_msb_sig`=1, the quieted form of a signaling NaN has two cases. Under convention code 2 it is the operand with the fraction top bit cleared and the next lower bit set. Under any other code it is the default NaN.
- R8: The default NaN always has an all-ones exponent. Its sign and fraction come from `in_conv`. Code 0 gives sign 0 and all fraction bits set. Code 1 gives sign 0 and only the top bit. Code 2 gives sign 0 and only the bit below the top. Code 3 gives sign 0 and all bits but the top. Code 4 gives sign 1 and only the top bit. Codes 5 to 7 give sign 0 with all bits but the top when `in_msb_sig`=1, and only the top bit when it is 0. Example single patterns: 7FFFFFFF, 7FC00000, 7FA00000, 7FBFFFFF, FFC00000.
- R9: For an operand that is not a signaling NaN (after R5), `out_quieted` equals the operand unchanged.
- R10: `in_dbl`=0 selects single precision. In that format only `in_value[31:0]` is used, and bits 63:32 of `out_quieted` and `out_default` are zero.
- R11: While `in_valid` is low, all result outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand strobe; loads the result registers |
| in_dbl | input | 1 | 1 = binary64, 0 = binary32 in bits 31:0 |
| in_value | input | 64 | Operand |
| in_msb_sig | input | 1 | 1 = set fraction top bit marks signaling |
| in_no_snan | input | 1 | 1 = treat every NaN as quiet |
| in_conv | input | 3 | Quieting and default-NaN convention code |
| out_valid | output | 1 | Results valid |
| out_is_qnan | output | 1 | Operand is a quiet NaN |
| out_is_snan | output | 1 | Operand is a signaling NaN |
| out_quieted | output | 64 | Quieted operand, zero-extended for single |
| out_default | output | 64 | Default NaN for the format, zero-extended for single |

## Verification
The hardest case to reach is a signaling NaN whose quieting depends on three controls at once: polarity, the no-signaling mode and the convention code. The case where the fraction is nonzero only in its top bit is also hard, because its class flips with polarity while it stays a NaN. The stimulus gets there with a cross product. It sweeps both formats, both signs, the edge exponents and a set of fraction patterns (zero, lone top bit, the bit below it, all ones, all but the top, the lowest bit alone). Each of these is applied under every polarity, mode and convention code. For single precision, garbage is placed in the unused upper half of the operand.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  // Convention codes for quieting and default-NaN generation
  localparam logic [2:0] CONV_ALL_ONES  = 3'd0;
  localparam logic [2:0] CONV_TOP_ONLY  = 3'd1;
  localparam logic [2:0] CONV_NEXT_ONLY = 3'd2;
  localparam logic [2:0] CONV_ALL_BUT   = 3'd3;
  localparam logic [2:0] CONV_NEG_TOP   = 3'd4;

  typedef struct packed {
    logic is_q;
    logic is_s;
  } nan_class_t;
endpackage

// File: rtl/nanq_dflt_gen.sv
module nanq_dflt_gen
  import nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [2:0]   conv,
  input  logic         msb_sig,
  output logic [W-1:0] dflt
);
  localparam logic [FRAC_W-1:0] TOP  = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] NEXT = {2'b01, {(FRAC_W-2){1'b0}}};
  localparam logic [FRAC_W-1:0] ALL  = {FRAC_W{1'b1}};

  logic              sgn;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sgn = 1'b0;
    case (conv)
      CONV_ALL_ONES:  frac = ALL;
      CONV_TOP_ONLY:  frac = TOP;
      CONV_NEXT_ONLY: frac = NEXT;
      CONV_ALL_BUT:   frac = ALL ^ TOP;
      CONV_NEG_TOP: begin
        frac = TOP;
        sgn  = 1'b1;
      end
      default:        frac = msb_sig ? (ALL ^ TOP) : TOP;
    endcase
    dflt = {sgn, {EXP_W{1'b1}}, frac};
  end
endmodule

// File: rtl/nanq_lane.sv
module nanq_lane
  import nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] value,
  input  logic         msb_sig,
  input  logic         no_snan,
  input  logic [2:0]   conv,
  output nan_class_t   cls,
  output logic [W-1:0] quieted,
  output logic [W-1:0] dflt
);
  localparam logic [W-1:0] TOP_BIT  = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] NEXT_BIT = W'(1) << (FRAC_W - 2);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              is_nan;
  logic              top;

  nanq_dflt_gen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
    .conv    (conv),
    .msb_sig (msb_sig),
    .dflt    (dflt)
  );

  always_comb begin
    exp_f  = value[W-2 -: EXP_W];
    frac_f = value[FRAC_W-1:0];
    is_nan = (&exp_f) && (|frac_f);
    top    = frac_f[FRAC_W-1];
    cls.is_s = is_nan && (top == msb_sig) && !no_snan;
    cls.is_q = is_nan && !cls.is_s;

    if (!cls.is_s) begin
      quieted = value;
    end else if (!msb_sig) begin
      quieted = value | TOP_BIT;
    end else if (conv == CONV_NEXT_ONLY) begin
      quieted = (value & ~TOP_BIT) | NEXT_BIT;
    end else begin
      quieted = dflt;
    end
  end
endmodule

// File: rtl/nan_shaper.sv
module nan_shaper
  import nanq_pkg::*;
#(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_dbl,
  input  logic [63:0] in_value,
  input  logic        in_msb_sig,
  input  logic        in_no_snan,
  input  logic [2:0]  in_conv,
  output logic        out_valid,
  output logic        out_is_qnan,
  output logic        out_is_snan,
  output logic [63:0] out_quieted,
  output logic [63:0] out_default
);
  localparam int SP_W = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W = 1 + DP_EXP + DP_FRAC;
  localparam int PAD  = DP_W - SP_W;

  nan_class_t        sp_cls, dp_cls, sel_cls;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [DP_W-1:0]   dp_q, dp_d;
  logic [63:0]       sel_q, sel_d;

  logic              valid_d, valid_r;
  nan_class_t        cls_d, cls_r;
  logic [63:0]       q_d, q_r, dft_d, dft_r;

  nanq_lane #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
    .value   (in_value[SP_W-1:0]),
    .msb_sig (in_msb_sig),
    .no_snan (in_no_snan),
    .conv    (in_conv),
    .cls     (sp_cls),
    .quieted (sp_q),
    .dflt    (sp_d)
  );

  nanq_lane #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
    .value   (in_value[DP_W-1:0]),
    .msb_sig (in_msb_sig),
    .no_snan (in_no_snan),
    .conv    (in_conv),
    .cls     (dp_cls),
    .quieted (dp_q),
    .dflt    (dp_d)
  );

  // Format select
  always_comb begin
    if (in_dbl) begin
      sel_cls = dp_cls;
      sel_q   = dp_q;
      sel_d   = dp_d;
    end else begin
      sel_cls = sp_cls;
      sel_q   = {{PAD{1'b0}}, sp_q};
      sel_d   = {{PAD{1'b0}}, sp_d};
    end
  end

  // Next-state: load on strobe, otherwise hold
  always_comb begin
    valid_d = in_valid;
    cls_d   = cls_r;
    q_d     = q_r;
    dft_d   = dft_r;
    if (in_valid) begin
      cls_d = sel_cls;
      q_d   = sel_q;
      dft_d = sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_r <= 1'b0;
      cls_r   <= '0;
      q_r     <= '0;
      dft_r   <= '0;
    end else begin
      valid_r <= valid_d;
      cls_r   <= cls_d;
      q_r     <= q_d;
      dft_r   <= dft_d;
    end
  end

  assign out_valid   = valid_r;
  assign out_is_qnan = cls_r.is_q;
  assign out_is_snan = cls_r.is_s;
  assign out_quieted = q_r;
  assign out_default = dft_r;
endmodule

// File: rtl/nanq_checker.sv
module nanq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_dbl,
  input logic [63:0] in_value,
  input logic        in_msb_sig,
  input logic        in_no_snan,
  input logic        out_valid,
  input logic        out_is_qnan,
  input logic        out_is_snan,
  input logic [63:0] out_quieted,
  input logic [63:0] out_default
);
  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2 / R3: classes exclusive
  a_r2_class_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_is_qnan, out_is_snan}));
  // R4: single infinity
  a_r4_inf_single: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dbl && in_value[30:0] == 31'h7F800000)
    |=> (!out_is_qnan && !out_is_snan));
  // R5
  a_r5_no_snan: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_no_snan) |=> !out_is_snan);
  // R6: single sNaN with polarity 0 gains top bit
  a_r6_quiet_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dbl && !in_msb_sig && !in_no_snan &&
     in_value[30:22] == 9'h1FE && in_value[21:0] != 22'd0)
    |=> (out_is_snan && out_quieted[22]));
  // R9: double finite passes through
  a_r9_pass_finite: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dbl && in_value[62:52] != 11'h7FF)
    |=> (out_quieted == $past(in_value)));
  // R10
  a_r10_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dbl) |=> (out_quieted[63:32] == 32'd0 && out_default[63:32] == 32'd0));
  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_quieted) && $stable(out_default) &&
                   $stable(out_is_qnan) && $stable(out_is_snan)));
endmodule

bind nan_shaper nanq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_dbl      (in_dbl),
  .in_value    (in_value),
  .in_msb_sig  (in_msb_sig),
  .in_no_snan  (in_no_snan),
  .out_valid   (out_valid),
  .out_is_qnan (out_is_qnan),
  .out_is_snan (out_is_snan),
  .out_quieted (out_quieted),
  .out_default (out_default)
);

// File: tb/sim_nan_shaper.sv
module sim_nan_shaper;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_dbl;
  logic [63:0] in_value;
  logic        in_msb_sig;
  logic        in_no_snan;
  logic [2:0]  in_conv;
  logic        out_valid;
  logic        out_is_qnan;
  logic        out_is_snan;
  logic [63:0] out_quieted;
  logic [63:0] out_default;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  nan_shaper u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
    .in_value(in_value), .in_msb_sig(in_msb_sig), .in_no_snan(in_no_snan),
    .in_conv(in_conv), .out_valid(out_valid), .out_is_qnan(out_is_qnan),
    .out_is_snan(out_is_snan), .out_quieted(out_quieted), .out_default(out_default)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (dbl=%0d val=%h pol=%0d nos=%0d conv=%0d)",
               tag, act, exp, in_dbl, in_value, in_msb_sig, in_no_snan, in_conv);
    end
  endtask

  // Reference model built from the requirements
  task automatic model(input bit dbl, input logic [63:0] v, input bit pol, input bit nos,
                       input int cv, output bit q, output bit s,
                       output logic [63:0] qv, output logic [63:0] dv);
    int f, e;
    logic [63:0] fm, em, vv, ex, fr, top, dfr, sgn;
    bit nan;
    f   = dbl ? 52 : 23;
    e   = dbl ? 11 : 8;
    fm  = (64'd1 << f) - 64'd1;
    em  = (64'd1 << e) - 64'd1;
    vv  = dbl ? v : (v & 64'hFFFF_FFFF);
    ex  = (vv >> f) & em;
    fr  = vv & fm;
    top = 64'd1 << (f - 1);
    nan = (ex == em) && (fr != 0);
    s   = nan && (((fr & top) != 0) == pol) && !nos;
    q   = nan && !s;
    sgn = 64'd0;
    case (cv)
      0: dfr = fm;
      1: dfr = top;
      2: dfr = top >> 1;
      3: dfr = top - 64'd1;
      4: begin dfr = top; sgn = 64'd1; end
      default: dfr = pol ? (top - 64'd1) : top;
    endcase
    dv = (sgn << (e + f)) | (em << f) | dfr;
    if (!s)            qv = vv;
    else if (!pol)     qv = vv | top;
    else if (cv == 2)  qv = (vv & ~top) | (top >> 1);
    else               qv = dv;
  endtask

  task automatic run_vec(input bit dbl, input logic [63:0] v, input bit pol,
                         input bit nos, input int cv, input bit is_inf);
    bit q, s;
    logic [63:0] qv, dv;
    string ctag, qtag;
    model(dbl, v, pol, nos, cv, q, s, qv, dv);
    @(negedge clk);
    in_valid   = 1'b1;
    in_dbl     = dbl;
    in_value   = v;
    in_msb_sig = pol;
    in_no_snan = nos;
    in_conv    = 3'(cv);
    @(negedge clk);
    chk("R1 valid", {63'd0, out_valid}, 64'd1);
    ctag = is_inf ? "R4 class" : (nos ? "R5 class" : (pol ? "R3 class" : "R2 class"));
    chk(ctag, {62'd0, out_is_qnan, out_is_snan}, {62'd0, q, s});
    qtag = !s ? "R9 quieted" : (pol ? "R7 quieted" : "R6 quieted");
    chk(qtag, out_quieted, qv);
    chk("R8 default", out_default, dv);
    if (!dbl) chk("R10 upper zero", out_quieted[63:32] | out_default[63:32], 64'd0);
    // R11: strobe low with disturbed inputs, results must hold
    in_valid   = 1'b0;
    in_value   = ~v;
    in_msb_sig = ~pol;
    in_conv    = ~in_conv;
    @(negedge clk);
    chk("R1 valid low", {63'd0, out_valid}, 64'd0);
    chk("R11 hold", out_quieted ^ out_default, qv ^ dv);
  endtask

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_dbl     = 1'b0;
    in_value   = '0;
    in_msb_sig = 1'b0;
    in_no_snan = 1'b0;
    in_conv    = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset data", out_quieted | out_default | {62'd0, out_is_qnan, out_is_snan}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {63'd0, out_valid}, 64'd0);

    for (int fmt = 0; fmt < 2; fmt++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int ei = 0; ei < 5; ei++) begin
          for (int fi = 0; fi < 7; fi++) begin
            for (int pol = 0; pol < 2; pol++) begin
              for (int nos = 0; nos < 2; nos++) begin
                for (int cv = 0; cv < 8; cv++) begin
                  int f, e;
                  logic [63:0] fm, em, top, ex, fr, v;
                  f   = fmt ? 52 : 23;
                  e   = fmt ? 11 : 8;
                  fm  = (64'd1 << f) - 64'd1;
                  em  = (64'd1 << e) - 64'd1;
                  top = 64'd1 << (f - 1);
                  case (ei)
                    0: ex = 64'd0;
                    1: ex = 64'd1;
                    2: ex = (em >> 1);
                    3: ex = em - 64'd1;
                    default: ex = em;
                  endcase
                  case (fi)
                    0: fr = 64'd0;
                    1: fr = 64'd1;
                    2: fr = top;
                    3: fr = top | 64'd1;
                    4: fr = top >> 1;
                    5: fr = fm;
                    default: fr = fm ^ top;
                  endcase
                  v = (64'(sg) << (e + f)) | (ex << f) | fr;
                  if (fmt == 0) v = v | 64'hDEAD_BEEF_0000_0000; // R10: ignored upper half
                  run_vec(fmt != 0, v, pol != 0, nos != 0, cv, (ei == 4) && (fi == 0));
                end
              end
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule